// File: doc/BRIEF.md
# Prioritized Interrupt Request Tracker

This block keeps the interrupt state of a single processor across 256 vectors. Three bit arrays hold that state: one marks requests that are waiting, one marks vectors in service, and one records the trigger mode of each vector. Incoming requests carry a vector number and a flag that says whether the source is level- or edge-triggered. The block presents the highest waiting vector that may interrupt the processor now. The core takes that vector with an accept strobe and later retires it with an end-of-interrupt strobe.

Delivery is gated by priority classes. A class is the upper four bits of a vector. The block forms a processor priority from a software-written task priority and the vector most recently put in service. A waiting vector is offered only when its class is strictly above the class of that processor priority. Nested in-service vectors are kept on a small stack whose bottom entry is always zero. When a level-triggered vector is retired, the block sends the vector out on a one-cycle broadcast, so that the source can be told that the interrupt has ended. Vectors 0 to 31 are reserved: they are never offered and never retired.

Top module: `prio_irq_tracker`

## Requirements
- R1: After reset nothing is pending, the processor priority reads 0 and no broadcast is active.
- R2: A request that arrives while sw_enable is 0 is dropped and never becomes pending, even after the block is enabled again.
- R3: A request that arrives while enabled marks the vector as waiting and records its trigger mode (req_level 1 = level, 0 = edge). A later request for the same vector overwrites the mode.
- R4: pend_vector is the highest waiting vector in the range 32 to 255. Vectors 0 to 31 are never presented.
- R5: pend_valid is 1 only when the class of the highest waiting vector (bits 7:4) is strictly greater than the class of ppr_out. An equal or lower class gives pend_valid 0.
- R6: ppr_out equals the task priority when the task priority's class is at least the class of the current in-service vector. Otherwise it equals the in-service vector with bits 3:0 cleared. With nothing in service, the in-service vector counts as 0.
- R7: ack_valid while pend_valid is 1 accepts pend_vector. The vector stops waiting, becomes in service, is pushed on the nesting stack and becomes the current in-service vector. ack_valid while pend_valid is 0 has no effect.
- R8: eoi_strobe retires the highest in-service vector, pops the stack and recomputes the priority. An accept in the same cycle as eoi_strobe is ignored.
- R9: Retiring a level-triggered vector makes eoi_bcast_valid 1 for exactly the following cycle, with eoi_bcast_vector set to the retired vector. Retiring an edge-triggered vector produces no broadcast.
- R10: A task-priority write stores bits 7:0 of tpr_wdata and ignores the higher bits.
- R11: The nesting stack holds one entry per class on top of the zero entry. Stacked classes rise strictly from bottom to top, so one vector from each class 2 to 15 can be in service at once.
- R12: ppr_out, pend_valid and pend_vector reflect an accept, an end-of-interrupt, a request or a task-priority write in the cycle right after the clock edge that takes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sw_enable | input | 1 | Global software enable; requests are dropped while it is 0 |
| req_valid | input | 1 | Incoming request strobe |
| req_vector | input | 8 | Vector of the incoming request |
| req_level | input | 1 | 1 = level-triggered, 0 = edge-triggered |
| pend_valid | output | 1 | A waiting vector may be delivered |
| pend_vector | output | 8 | Vector offered for delivery |
| ack_valid | input | 1 | Core accepts the offered vector |
| eoi_strobe | input | 1 | End of interrupt for the highest in-service vector |
| tpr_we | input | 1 | Task-priority write strobe |
| tpr_wdata | input | 32 | Task-priority write data; only bits 7:0 are kept |
| ppr_out | output | 8 | Current processor priority |
| eoi_bcast_valid | output | 1 | One-cycle broadcast for a retired level-triggered vector |
| eoi_bcast_vector | output | 8 | Vector carried by the broadcast |

## Verification
The assertions watch the following on every cycle:
- an offered vector always lies above the reserved range and in a class above the processor priority;
- the nesting stack keeps strictly rising classes, never overflows and is never popped when empty;
- an accept while nothing is offered leaves the in-service state untouched;
- a broadcast always follows an end-of-interrupt;
- a request dropped while disabled never sets a waiting bit.

Only the directed scenarios can show the values that result:
- which vector wins among several waiting ones;
- the exact priority after a task-priority write or an unwind;
- whether the broadcast carries the right vector for level sources and stays silent for edge sources;
- that a request taken while disabled stays lost after enabling.

// File: rtl/prio_irq_tracker.sv
module prio_irq_tracker #(
  parameter int VEC_W     = 8,
  parameter int CLS_W     = 4,
  parameter int RSVD_VEC  = 32,
  parameter int STK_DEPTH = 16,
  parameter int REG_W     = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sw_enable,
  input  logic             req_valid,
  input  logic [VEC_W-1:0] req_vector,
  input  logic             req_level,
  output logic             pend_valid,
  output logic [VEC_W-1:0] pend_vector,
  input  logic             ack_valid,
  input  logic             eoi_strobe,
  input  logic             tpr_we,
  input  logic [REG_W-1:0] tpr_wdata,
  output logic [VEC_W-1:0] ppr_out,
  output logic             eoi_bcast_valid,
  output logic [VEC_W-1:0] eoi_bcast_vector
);
  localparam int NUM_VEC = 1 << VEC_W;
  localparam int SUB_W   = VEC_W - CLS_W;
  localparam int SP_W    = $clog2(STK_DEPTH + 1);

  // waiting / in-service / trigger-mode bits, one per vector
  logic [NUM_VEC-1:0] irr_q, isr_q, tmr_q;
  logic [VEC_W-1:0]   stk_q [STK_DEPTH+1];
  logic [SP_W-1:0]    sp_q;
  logic [VEC_W-1:0]   tpr_q;
  logic               bc_v_q;
  logic [VEC_W-1:0]   bc_vec_q;

  function automatic logic [VEC_W:0] top_set(input logic [NUM_VEC-1:0] bits);
    logic [VEC_W:0] r;
    r = '0;
    for (int v = RSVD_VEC; v < NUM_VEC; v++)
      if (bits[v]) r = {1'b1, VEC_W'(v)};
    return r;
  endfunction

  logic [VEC_W:0]   irr_top, isr_top;
  logic [VEC_W-1:0] cur_isv;
  logic             acc_fire, eoi_fire;
  logic [SP_W-1:0]  sp_inc;

  assign irr_top  = top_set(irr_q);
  assign isr_top  = top_set(isr_q);
  assign cur_isv  = stk_q[sp_q];
  assign ppr_out  = (tpr_q[VEC_W-1:SUB_W] >= cur_isv[VEC_W-1:SUB_W]) ? tpr_q
                    : {cur_isv[VEC_W-1:SUB_W], {SUB_W{1'b0}}};
  assign pend_vector = irr_top[VEC_W-1:0];
  assign pend_valid  = irr_top[VEC_W] && (irr_top[VEC_W-1:SUB_W] > ppr_out[VEC_W-1:SUB_W]);
  assign acc_fire = ack_valid && pend_valid && !eoi_strobe;
  assign eoi_fire = eoi_strobe && isr_top[VEC_W];
  assign sp_inc   = sp_q + 1'b1;
  assign eoi_bcast_valid  = bc_v_q;
  assign eoi_bcast_vector = bc_vec_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irr_q    <= '0;
      isr_q    <= '0;
      tmr_q    <= '0;
      sp_q     <= '0;
      tpr_q    <= '0;
      bc_v_q   <= 1'b0;
      bc_vec_q <= '0;
      for (int i = 0; i <= STK_DEPTH; i++) stk_q[i] <= '0;
    end else begin
      bc_v_q <= 1'b0;
      if (eoi_fire) begin
        isr_q[isr_top[VEC_W-1:0]] <= 1'b0;
        if (sp_q != '0) sp_q <= sp_q - 1'b1;
        bc_v_q   <= tmr_q[isr_top[VEC_W-1:0]];
        bc_vec_q <= isr_top[VEC_W-1:0];
      end
      if (acc_fire) begin
        irr_q[pend_vector] <= 1'b0;
        isr_q[pend_vector] <= 1'b1;
        if (sp_q < SP_W'(STK_DEPTH)) begin
          sp_q          <= sp_inc;
          stk_q[sp_inc] <= pend_vector;
        end
      end
      if (req_valid && sw_enable) begin
        irr_q[req_vector] <= 1'b1;
        tmr_q[req_vector] <= req_level;
      end
      if (tpr_we) tpr_q <= tpr_wdata[VEC_W-1:0];
    end
  end

  a_r5_pend_class: assert property (@(posedge clk) disable iff (!rst_n)
    pend_valid |-> (pend_vector >= VEC_W'(RSVD_VEC)) &&
                   (pend_vector[VEC_W-1:SUB_W] > ppr_out[VEC_W-1:SUB_W]));
  a_r11_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    acc_fire |-> sp_q < SP_W'(STK_DEPTH));
  a_r11_rising_classes: assert property (@(posedge clk) disable iff (!rst_n)
    (sp_q != '0) |-> stk_q[sp_q][VEC_W-1:SUB_W] > stk_q[sp_q - 1'b1][VEC_W-1:SUB_W]);
  a_r8_eoi_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
    eoi_strobe |-> sp_q != '0);
  a_r7_ack_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_valid && !pend_valid && !eoi_strobe) |=> $stable(isr_q));
  a_r9_bcast_after_eoi: assert property (@(posedge clk) disable iff (!rst_n)
    eoi_bcast_valid |-> $past(eoi_strobe));
  a_r2_drop_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !sw_enable && !irr_q[req_vector]) |=> !irr_q[$past(req_vector)]);
endmodule

// File: tb/test_prio_irq_tracker.sv
module test_prio_irq_tracker;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sw_enable = 1'b0, req_valid = 1'b0, req_level = 1'b0;
  logic [7:0] req_vector = '0;
  logic ack_valid = 1'b0, eoi_strobe = 1'b0, tpr_we = 1'b0;
  logic [31:0] tpr_wdata = '0;
  logic pend_valid, eoi_bcast_valid;
  logic [7:0] pend_vector, ppr_out, eoi_bcast_vector;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  prio_irq_tracker i_prio_irq_tracker (
    .clk(clk), .rst_n(rst_n), .sw_enable(sw_enable),
    .req_valid(req_valid), .req_vector(req_vector), .req_level(req_level),
    .pend_valid(pend_valid), .pend_vector(pend_vector),
    .ack_valid(ack_valid), .eoi_strobe(eoi_strobe),
    .tpr_we(tpr_we), .tpr_wdata(tpr_wdata), .ppr_out(ppr_out),
    .eoi_bcast_valid(eoi_bcast_valid), .eoi_bcast_vector(eoi_bcast_vector));

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(); @(negedge clk); endtask
  task automatic do_req(logic [7:0] v, logic lvl);
    req_valid = 1'b1; req_vector = v; req_level = lvl; tick(); req_valid = 1'b0;
  endtask
  task automatic do_ack(); ack_valid = 1'b1; tick(); ack_valid = 1'b0; endtask
  task automatic do_eoi(); eoi_strobe = 1'b1; tick(); eoi_strobe = 1'b0; endtask
  task automatic do_tpr(logic [31:0] d); tpr_we = 1'b1; tpr_wdata = d; tick(); tpr_we = 1'b0; endtask

  task automatic t_reset();
    check("R1 pend_valid", pend_valid, 0);
    check("R1 ppr", ppr_out, 0);
    check("R1 bcast", eoi_bcast_valid, 0);
  endtask

  task automatic t_disabled();
    sw_enable = 1'b0;
    do_req(8'h50, 1'b0);
    check("R2 dropped while disabled", pend_valid, 0);
    sw_enable = 1'b1; tick();
    check("R2 stays dropped after enable", pend_valid, 0);
  endtask

  task automatic t_reserved();
    do_req(8'h10, 1'b0);
    check("R4 reserved vector not offered", pend_valid, 0);
    do_ack();
    check("R7 ack with nothing pending ignored", ppr_out, 0);
  endtask

  task automatic t_deep_nest();
    for (int c = 2; c < 16; c++) begin
      do_req(8'((c << 4) | 3), 1'(c & 1));
      check("R12 pend after request", pend_valid, 1);
      check("R4 pend vector", pend_vector, 32'((c << 4) | 3));
      do_ack();
      check("R11 ppr after nested accept", ppr_out, 32'(c << 4));
      check("R7 accepted vector no longer pending", pend_valid, 0);
    end
    for (int c = 15; c >= 2; c--) begin
      do_eoi();
      check("R9 bcast for level only", eoi_bcast_valid, 32'(c & 1));
      if ((c & 1) == 1) check("R9 bcast vector", eoi_bcast_vector, 32'((c << 4) | 3));
      check("R8 ppr after unwind", ppr_out, (c == 2) ? 0 : 32'((c - 1) << 4));
    end
    tick();
    check("R9 bcast lasts one cycle", eoi_bcast_valid, 0);
  endtask

  task automatic t_mixed();
    do_req(8'h41, 1'b0);
    do_req(8'h93, 1'b1);
    do_req(8'h62, 1'b0);
    check("R4 highest of three", pend_vector, 8'h93);
    check("R5 offered", pend_valid, 1);
    do_ack();
    check("R6 ppr from in-service", ppr_out, 8'h90);
    check("R5 lower class blocked", pend_valid, 0);
    do_tpr(32'h1A5);
    check("R10 low byte kept", ppr_out, 8'hA5);
    do_tpr(32'h20);
    check("R6 in-service class wins", ppr_out, 8'h90);
    do_req(8'hB7, 1'b0);
    check("R5 higher class offered", pend_vector, 8'hB7);
    do_ack();
    check("R7 ppr after accept", ppr_out, 8'hB0);
    do_eoi();
    check("R9 edge vector no bcast", eoi_bcast_valid, 0);
    check("R8 ppr after eoi", ppr_out, 8'h90);
    check("R5 0x62 still blocked", pend_valid, 0);
    do_eoi();
    check("R9 level vector bcast", eoi_bcast_valid, 1);
    check("R9 bcast carries vector", eoi_bcast_vector, 8'h93);
    check("R6 ppr back to task priority", ppr_out, 8'h20);
    check("R12 0x62 offered", pend_vector, 8'h62);
    tick();
    check("R9 pulse ends", eoi_bcast_valid, 0);
  endtask

  task automatic t_eoi_over_ack();
    do_ack();
    check("R7 ppr 0x60", ppr_out, 8'h60);
    do_req(8'hD0, 1'b0);
    check("R4 D0 offered", pend_vector, 8'hD0);
    ack_valid = 1'b1; eoi_strobe = 1'b1; tick(); ack_valid = 1'b0; eoi_strobe = 1'b0;
    check("R8 eoi retires 0x62", ppr_out, 8'h20);
    check("R8 accept ignored", pend_vector, 8'hD0);
    check("R8 D0 still offered", pend_valid, 1);
  endtask

  task automatic t_equal_class();
    do_ack();
    check("R7 ppr D0", ppr_out, 8'hD0);
    do_req(8'hDF, 1'b1);
    check("R5 equal class blocked", pend_valid, 0);
    do_req(8'hE1, 1'b0);
    check("R5 E1 offered", pend_vector, 8'hE1);
    do_ack();
    do_eoi();
    check("R8 ppr D0 again", ppr_out, 8'hD0);
    check("R5 still blocked", pend_valid, 0);
    do_eoi();
    check("R6 ppr to task priority", ppr_out, 8'h20);
    check("R4 DF offered", pend_vector, 8'hDF);
    do_req(8'hDF, 1'b0);
    do_ack();
    do_eoi();
    check("R3 mode overwritten to edge", eoi_bcast_valid, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    tick();
    t_reset();
    t_disabled();
    t_reserved();
    t_deep_nest();
    t_mixed();
    t_eoi_over_ack();
    t_equal_class();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule